// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block holds up to four instruction bytes between the memory bus and the CPU's decoder. The CPU asks for one or two bytes at a time. The oldest queued byte is presented on the low byte of `cpu_data_o`. When enough bytes are present, the request is granted and those bytes leave the queue at the next clock edge. When too few are present, `stall_o` holds the CPU.

Refills go through a bus sequencer on a simple request/acknowledge/done port, with one fetch in flight at a time. A fetch is issued in three cases: on demand while the CPU is stalled, speculatively when the queue is empty, or speculatively when one byte is left and the bus will be free next cycle. An even address fetches a byte pair. An odd address fetches a single byte. An address in the external area fetches a single byte when the external bus is eight bits wide. A flush input carries a new fetch address, discards the queue and cancels the data of any fetch already under way.

A four-state machine orders the fetch traffic:
- `FS_IDLE`: no fetch pending.
- `FS_ISSUE`: the request is held on the port.
- `FS_AWAIT`: the request was accepted and its data is due.
- `FS_DRAIN`: a flush cancelled the fetch and its data must be swallowed.

Transitions:
- issue: `FS_IDLE` to `FS_ISSUE`, when a trigger is present and the bytes fit.
- accept: `FS_ISSUE` to `FS_AWAIT`, on acknowledge.
- withdraw: `FS_ISSUE` to `FS_IDLE`, on flush without acknowledge.
- cancel: to `FS_DRAIN`, from `FS_AWAIT` on flush, or from `FS_ISSUE` on acknowledge and flush together.
- land: `FS_AWAIT` to `FS_IDLE`, on done.
- swallow: `FS_DRAIN` to `FS_IDLE`, on done.

Top module: `ifq_ctrl`

## Requirements
- R1: `stall_o` is high exactly when `cpu_req_i` is high and either `flush_i` is high or the queue holds fewer bytes than requested. The request size is one byte when `cpu_two_i`=0 and two bytes when `cpu_two_i`=1.
- R2: A granted request removes its bytes from the head. `cpu_data_o[7:0]` is the oldest byte and `cpu_data_o[15:8]` is the next one, in fetch address order.
- R3: With no CPU request and an empty queue, a fetch is issued.
- R4: With one byte queued, no CPU request and `bus_idle_next_i`=1, a fetch is issued. With `bus_idle_next_i`=0 in the same state, no fetch is issued.
- R5: A fetch from an even address has `fetch_two_o`=1, unless R7 applies. The byte at the even address returns on `fetch_data_i[7:0]` and the byte at the next address on `fetch_data_i[15:8]`, and both are queued.
- R6: A fetch from an odd address has `fetch_two_o`=0, and only `fetch_data_i[7:0]` is queued.
- R7: A fetch from an address at or above EXT_BASE (default 16'h8000) while `bus8_i`=1 has `fetch_two_o`=0. Addresses below EXT_BASE are unaffected by `bus8_i`.
- R8: The queue never holds more than DEPTH (4) bytes. A fetch is issued only when its bytes fit in the free space.
- R9: After each completed fetch, the fetch address advances by the number of bytes read (1 or 2).
- R10: A flush empties the queue and loads the fetch address from `redirect_addr_i`. Data returning for a fetch that was in flight at the flush is discarded, and no new request is raised until that data has returned.
- R11: A pop and a fetch return in the same cycle both take effect: the returned bytes queue behind the bytes that remain.
- R12: While the CPU is stalled and no fetch is pending, a fetch is issued. A raised request holds its address and width until acknowledged or flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | CPU wants instruction bytes this cycle |
| cpu_two_i | input | 1 | Request size: 0 = one byte, 1 = two bytes |
| stall_o | output | 1 | CPU must hold its request |
| cpu_data_o | output | 16 | Two oldest queued bytes, oldest in [7:0] |
| fetch_req_o | output | 1 | Fetch request to the bus sequencer |
| fetch_addr_o | output | ADDR_W | Fetch address |
| fetch_two_o | output | 1 | 1 = byte pair, 0 = single byte |
| fetch_ack_i | input | 1 | Sequencer accepted the request |
| fetch_done_i | input | 1 | Fetch data valid |
| fetch_data_i | input | 16 | Returned bytes, lower address in [7:0] |
| bus_idle_next_i | input | 1 | Bus will be free next cycle |
| bus8_i | input | 1 | External data bus is 8 bits wide |
| flush_i | input | 1 | Discard queue and redirect |
| redirect_addr_i | input | ADDR_W | New fetch address on flush |

## Verification
The assertions assume the following about the sequencer:
- It acknowledges only a raised request.
- It signals done only after the acknowledge cycle.
- It returns data exactly once per accepted fetch.
- `bus8_i` stays still while a fetch is pending.

The bench plays the sequencer itself under these rules. It acknowledges in the cycle after it sees a request and returns data one cycle later. It changes `bus8_i` and `bus_idle_next_i` only between fetches. It raises a flush only in idle or waiting phases whose outcome it can predict.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ISSUE = 2'd1,
        FS_AWAIT = 2'd2,
        FS_DRAIN = 2'd3
    } fetch_state_e;
endpackage

// File: rtl/ifq_size.sv
module ifq_size #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] EXT_BASE = 16'h8000
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              bus8_i,
    output logic              two_o
);
    localparam logic [ADDR_W-1:0] EXT_C = ADDR_W'(EXT_BASE);

    logic is_ext;

    always_comb begin
        is_ext = (addr_i >= EXT_C);
        two_o  = !addr_i[0] && !(is_ext && bus8_i);
    end
endmodule

// File: rtl/ifq_store.sv
module ifq_store #(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [1:0]       pop_n_i,
    input  logic [1:0]       push_n_i,
    input  logic [15:0]      push_data_i,
    output logic [15:0]      head_o,
    output logic [CNT_W-1:0] count_o
);
    logic [7:0]       q     [DEPTH];
    logic [7:0]       sh    [DEPTH];
    logic [7:0]       nxt   [DEPTH];
    logic [CNT_W-1:0] keep;

    always_comb begin
        keep = count_o - CNT_W'(pop_n_i);
        for (int i = 0; i < DEPTH; i++) begin
            sh[i] = 8'h00;
            for (int j = 0; j < DEPTH; j++) begin
                if (j == i + int'(pop_n_i)) sh[i] = q[j];
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(keep)) begin
                nxt[i] = sh[i];
            end else if (i == int'(keep) && push_n_i != 2'd0) begin
                nxt[i] = push_data_i[7:0];
            end else if (i == int'(keep) + 1 && push_n_i == 2'd2) begin
                nxt[i] = push_data_i[15:8];
            end else begin
                nxt[i] = 8'h00;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= 8'h00;
        end else if (clear_i) begin
            count_o <= '0;
        end else begin
            count_o <= keep + CNT_W'(push_n_i);
            for (int i = 0; i < DEPTH; i++) q[i] <= nxt[i];
        end
    end

    assign head_o = {q[1], q[0]};

    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_n_i) <= int'(count_o));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (int'(count_o) - int'(pop_n_i) + int'(push_n_i) <= DEPTH));
endmodule

// File: rtl/ifq_fsm.sv
module ifq_fsm
    import ifq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         want_i,
    input  logic         ack_i,
    input  logic         done_i,
    output fetch_state_e state_o,
    output logic         issue_o,
    output logic         land_o,
    output logic         req_o
);
    fetch_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_o <= FS_IDLE;
        else        state_o <= nxt;
    end

    always_comb begin
        nxt = state_o;
        unique case (state_o)
            FS_IDLE: begin
                if (!flush_i && want_i) nxt = FS_ISSUE;
            end
            FS_ISSUE: begin
                if (ack_i)        nxt = flush_i ? FS_DRAIN : FS_AWAIT;
                else if (flush_i) nxt = FS_IDLE;
            end
            FS_AWAIT: begin
                if (done_i)       nxt = FS_IDLE;
                else if (flush_i) nxt = FS_DRAIN;
            end
            FS_DRAIN: begin
                if (done_i) nxt = FS_IDLE;
            end
            default: nxt = FS_IDLE;
        endcase
    end

    always_comb begin
        issue_o = 1'b0;
        land_o  = 1'b0;
        req_o   = 1'b0;
        unique case (state_o)
            FS_IDLE:  issue_o = !flush_i && want_i;
            FS_ISSUE: req_o   = 1'b1;
            FS_AWAIT: land_o  = done_i && !flush_i;
            FS_DRAIN: ;
            default:  ;
        endcase
    end

    p_done_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> (state_o == FS_AWAIT || state_o == FS_DRAIN));
endmodule

// File: rtl/ifq_ctrl.sv
module ifq_ctrl
    import ifq_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DEPTH    = 4,
    parameter logic [15:0] EXT_BASE = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic              cpu_two_i,
    output logic              stall_o,
    output logic [15:0]       cpu_data_o,
    output logic              fetch_req_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              fetch_two_o,
    input  logic              fetch_ack_i,
    input  logic              fetch_done_i,
    input  logic [15:0]       fetch_data_i,
    input  logic              bus_idle_next_i,
    input  logic              bus8_i,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] redirect_addr_i
);
    localparam int               CNT_W   = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    fetch_state_e     state;
    logic [CNT_W-1:0] count, room, need, len;
    logic [ADDR_W-1:0] ptr;
    logic             two_now, two_q, trig, want, issue, land;
    logic [1:0]       pop_n, push_n;

    always_comb begin
        len     = cpu_two_i ? CNT_W'(2) : CNT_W'(1);
        stall_o = cpu_req_i && (flush_i || count < len);
        pop_n   = (cpu_req_i && !stall_o) ? (cpu_two_i ? 2'd2 : 2'd1) : 2'd0;
        push_n  = land ? (two_q ? 2'd2 : 2'd1) : 2'd0;
        need    = two_now ? CNT_W'(2) : CNT_W'(1);
        room    = DEPTH_C - count;
        trig    = (count == '0)
               || (count == CNT_W'(1) && bus_idle_next_i)
               || (cpu_req_i && count < len);
        want    = trig && (need <= room);
    end

    ifq_size #(.ADDR_W(ADDR_W), .EXT_BASE(EXT_BASE)) u_size (
        .addr_i (ptr),
        .bus8_i (bus8_i),
        .two_o  (two_now)
    );

    ifq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush_i),
        .want_i  (want),
        .ack_i   (fetch_ack_i),
        .done_i  (fetch_done_i),
        .state_o (state),
        .issue_o (issue),
        .land_o  (land),
        .req_o   (fetch_req_o)
    );

    ifq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (flush_i),
        .pop_n_i     (pop_n),
        .push_n_i    (push_n),
        .push_data_i (fetch_data_i),
        .head_o      (cpu_data_o),
        .count_o     (count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr   <= '0;
            two_q <= 1'b0;
        end else begin
            if (issue) two_q <= two_now;
            if (flush_i)   ptr <= redirect_addr_i;
            else if (land) ptr <= ptr + (two_q ? ADDR_W'(2) : ADDR_W'(1));
        end
    end

    assign fetch_addr_o = ptr;
    assign fetch_two_o  = two_q;

    p_prefetch_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_IDLE && count == '0 && !flush_i) |=> fetch_req_o);

    p_prefetch_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_IDLE && count == CNT_W'(1) && bus_idle_next_i && !flush_i)
        |=> fetch_req_o);

    p_single_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fetch_addr_o[0]) |-> !fetch_two_o);

    p_single_ext8_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && bus8_i && fetch_addr_o >= ADDR_W'(EXT_BASE)) |-> !fetch_two_o);

    p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_AWAIT && fetch_done_i && !flush_i)
        |=> fetch_addr_o == $past(fetch_addr_o) + ($past(fetch_two_o) ? ADDR_W'(2) : ADDR_W'(1)));

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (fetch_addr_o == $past(redirect_addr_i) && count == '0));

    p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && !fetch_ack_i && !flush_i)
        |=> (fetch_req_o && $stable(fetch_addr_o) && $stable(fetch_two_o)));
endmodule

// File: tb/ifq_ctrl_tb.sv
module ifq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_i = 1'b0, cpu_two_i = 1'b0;
    logic        stall_o, fetch_req_o, fetch_two_o;
    logic [15:0] cpu_data_o, fetch_addr_o;
    logic        fetch_ack_i = 1'b0, fetch_done_i = 1'b0;
    logic [15:0] fetch_data_i = 16'h0000;
    logic        bus_idle_next_i = 1'b0, bus8_i = 1'b0, flush_i = 1'b0;
    logic [15:0] redirect_addr_i = 16'h0000;
    int          total = 0, bad = 0;

    always #10 clk = ~clk;

    ifq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req_i(cpu_req_i), .cpu_two_i(cpu_two_i),
        .stall_o(stall_o), .cpu_data_o(cpu_data_o), .fetch_req_o(fetch_req_o),
        .fetch_addr_o(fetch_addr_o), .fetch_two_o(fetch_two_o),
        .fetch_ack_i(fetch_ack_i), .fetch_done_i(fetch_done_i),
        .fetch_data_i(fetch_data_i), .bus_idle_next_i(bus_idle_next_i),
        .bus8_i(bus8_i), .flush_i(flush_i), .redirect_addr_i(redirect_addr_i)
    );

    function automatic logic [7:0] mb(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sequencer model: wait for a request, check it, acknowledge, return data.
    task automatic serve(input logic [15:0] a, input bit two, input bit pop1, input logic [7:0] pexp);
        int w = 0;
        @(negedge clk); #1;
        while (!fetch_req_o && w < 40) begin @(negedge clk); #1; w++; end
        chk(fetch_req_o == 1'b1, "R3/R4/R12 request raised", 32'(fetch_req_o), 1);
        chk(fetch_addr_o == a, "R9/R10 fetch address", 32'(fetch_addr_o), 32'(a));
        chk(fetch_two_o == two, "R5/R6/R7 fetch width", 32'(fetch_two_o), 32'(two));
        fetch_ack_i = 1'b1;
        @(negedge clk);
        fetch_ack_i  = 1'b0;
        fetch_done_i = 1'b1;
        fetch_data_i = two ? {mb(a + 16'd1), mb(a)} : {8'hEE, mb(a)};
        if (pop1) begin
            cpu_req_i = 1'b1; cpu_two_i = 1'b0; #1;
            chk(stall_o == 1'b0, "R11 pop with return", 32'(stall_o), 0);
            chk(cpu_data_o[7:0] == pexp, "R11 popped byte", 32'(cpu_data_o[7:0]), 32'(pexp));
        end
        @(negedge clk);
        fetch_done_i = 1'b0;
        if (pop1) cpu_req_i = 1'b0;
    endtask

    task automatic pop(input bit two, input logic [15:0] exp, input string req);
        @(negedge clk);
        cpu_req_i = 1'b1; cpu_two_i = two; #1;
        chk(stall_o == 1'b0, req, 32'(stall_o), 0);
        if (two) chk(cpu_data_o == exp, req, 32'(cpu_data_o), 32'(exp));
        else     chk(cpu_data_o[7:0] == exp[7:0], req, 32'(cpu_data_o[7:0]), 32'(exp[7:0]));
        @(negedge clk);
        cpu_req_i = 1'b0;
    endtask

    task automatic quiet(input string req);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk(fetch_req_o == 1'b0, req, 32'(fetch_req_o), 0);
        end
    endtask

    task automatic flush_to(input logic [15:0] a);
        @(negedge clk);
        flush_i = 1'b1; redirect_addr_i = a;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    task automatic t_reset();
        cpu_req_i = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(fetch_req_o == 1'b0, "R3 no request in reset", 32'(fetch_req_o), 0);
        chk(stall_o == 1'b1, "R1 stall when empty", 32'(stall_o), 1);
        cpu_req_i = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_fill_and_idle();
        serve(16'h0000, 1'b1, 1'b0, 8'h00);                                // R3, R5
        pop(1'b0, {8'h00, mb(16'h0000)}, "R2 pop one byte");
        quiet("R4 no prefetch with one byte, bus busy");
        bus_idle_next_i = 1'b1;
        serve(16'h0002, 1'b1, 1'b0, 8'h00);                                // R4, R9
        quiet("R8 no fetch with three bytes queued");
        bus_idle_next_i = 1'b0;
        pop(1'b1, {mb(16'h0002), mb(16'h0001)}, "R2 pop pair in order");
    endtask

    task automatic t_demand();
        @(negedge clk);
        cpu_req_i = 1'b1; cpu_two_i = 1'b1; #1;
        chk(stall_o == 1'b1, "R1 stall on short queue", 32'(stall_o), 1);
        serve(16'h0004, 1'b1, 1'b0, 8'h00);                                // R12
        #1;
        chk(stall_o == 1'b0, "R1 stall released", 32'(stall_o), 0);
        chk(cpu_data_o == {mb(16'h0004), mb(16'h0003)}, "R12 demand data",
            32'(cpu_data_o), 32'({mb(16'h0004), mb(16'h0003)}));
        @(negedge clk);
        cpu_req_i = 1'b0;
    endtask

    task automatic t_odd();
        flush_to(16'h0011);
        serve(16'h0011, 1'b0, 1'b0, 8'h00);                                // R6, R10
        pop(1'b0, {8'h00, mb(16'h0011)}, "R10 old bytes discarded");
        serve(16'h0012, 1'b1, 1'b0, 8'h00);                                // R9 advance by one
    endtask

    task automatic t_ext();
        bus8_i = 1'b1;
        flush_to(16'h8000);
        serve(16'h8000, 1'b0, 1'b0, 8'h00);                                // R7
        pop(1'b0, {8'h00, mb(16'h8000)}, "R7 single external byte");
        serve(16'h8001, 1'b0, 1'b0, 8'h00);                                // R9
        flush_to(16'h0004);
        serve(16'h0004, 1'b1, 1'b0, 8'h00);                                // R7 internal pair
        bus8_i = 1'b0;
    endtask

    task automatic t_cancel();
        int w = 0;
        flush_to(16'h0020);
        @(negedge clk); #1;
        while (!fetch_req_o && w < 40) begin @(negedge clk); #1; w++; end
        chk(fetch_addr_o == 16'h0020, "R10 redirect address", 32'(fetch_addr_o), 32'h20);
        fetch_ack_i = 1'b1;
        @(negedge clk);
        fetch_ack_i = 1'b0; flush_i = 1'b1; redirect_addr_i = 16'h0040;
        @(negedge clk);
        flush_i = 1'b0; fetch_done_i = 1'b1; fetch_data_i = 16'hDEAD; #1;
        chk(fetch_req_o == 1'b0, "R10 no request while draining", 32'(fetch_req_o), 0);
        @(negedge clk);
        fetch_done_i = 1'b0;
        serve(16'h0040, 1'b1, 1'b0, 8'h00);
        pop(1'b0, {8'h00, mb(16'h0040)}, "R10 cancelled data dropped");
    endtask

    task automatic t_overlap();
        bus_idle_next_i = 1'b1;
        serve(16'h0042, 1'b1, 1'b1, mb(16'h0041));                         // R11
        bus_idle_next_i = 1'b0;
        pop(1'b1, {mb(16'h0043), mb(16'h0042)}, "R11 count after overlap");
    endtask

    initial begin
        t_reset();
        t_fill_and_idle();
        t_demand();
        t_odd();
        t_ext();
        t_cancel();
        t_overlap();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule